// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block sits between instruction decode and the data-memory port of a single-register load/store path. For each accepted request it computes the address the access uses and the new value for the base register. It also reports whether that new value should be written back, the access width and the direction. For loads it extends the raw memory word to a full register value, and for stores it trims the register value to the access width.

The access is steered by a five-bit control field that holds the pre/post select, the up/down select, the byte select, the writeback request and the load flag. The offset comes from one of three places: a 12-bit immediate, an 8-bit immediate assembled from two 4-bit halves, or a full register value. The shifted-register offset is prepared elsewhere and arrives here as a plain register value.

Two size modes are supported. In word/byte mode the byte-select bit chooses between a word access and an unsigned byte access. In halfword/signed mode a two-bit extension code chooses between signed and unsigned accesses of a byte or a halfword. The block is combinational from input to result, with a single register stage on its outputs that captures once per valid request. It also flags a load whose destination register is its own base register when writeback is requested. In that case the loaded value wins and the writeback is dropped.

Top module: `lsu_addr_gen`

## Requirements
- R1: All results are registered. A request presented with `req_valid` high at a rising clock edge appears on the outputs right after that edge, with `out_valid` high. When `req_valid` is low, `out_valid` is low on the next cycle and every other output keeps its value. Reset clears every output to zero.
- R2: `off_kind` selects the offset. 0 selects `imm12` zero-extended, 1 selects `{imm_hi, imm_lo}` zero-extended, 2 selects `reg_off`, and 3 selects a zero offset.
- R3: With the up bit (`ctl_field[3]`) at 1 the offset is added to the base. With it at 0 the offset is subtracted. Both wrap modulo 2^32.
- R4: Post-indexed form (`ctl_field[4]`=0): `eff_addr` equals the unmodified base, `wb_value` equals base plus or minus the offset, and writeback is always requested.
- R5: Pre-indexed form (`ctl_field[4]`=1): `eff_addr` equals base plus or minus the offset, and `wb_value` equals `eff_addr`. Writeback is requested only when the writeback bit (`ctl_field[1]`) is 1.
- R6: `ctl_field[0]` is the load flag (1 = load, 0 = store), and `is_load` reports it.
- R7: In word/byte mode (`half_mode`=0), the byte-select bit `ctl_field[2]` chooses the access. A value of 1 gives a byte access (`acc_size`=0) whose load result is `mem_rdata[7:0]` zero-extended. A value of 0 gives a word access (`acc_size`=2) whose load result is `mem_rdata` unchanged.
- R8: In halfword/signed mode (`half_mode`=1), `ctl_field[2]` is ignored and `ext_code` decides the access. 0 is an unsigned byte (size 0, zero-extend bit 7 down), 1 is an unsigned halfword (size 1, zero-extend), 2 is a signed byte (size 0, bit 7 replicated upward) and 3 is a signed halfword (size 1, bit 15 replicated upward).
- R9: For stores, `store_data` carries only the low 8 or 16 bits of `st_wdata` (zero above) for byte and halfword accesses, and the full word for word accesses, while `load_result` is zero. For loads, `store_data` is zero.
- R10: The conflict case is a load with writeback requested and `dst_idx` equal to `base_idx`. In that case `wb_conflict` is 1 and `wb_en` is 0, because the loaded value takes priority. In every other case `wb_conflict` is 0 and `wb_en` follows R4/R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| ctl_field | input | 5 | {pre, up, byte-select, writeback, load} from bit 4 down to bit 0 |
| off_kind | input | 2 | Offset source select |
| half_mode | input | 1 | 0 = word/byte mode, 1 = halfword/signed mode |
| ext_code | input | 2 | Halfword/signed mode access kind |
| imm12 | input | 12 | 12-bit immediate offset |
| imm_hi | input | 4 | Upper half of split immediate |
| imm_lo | input | 4 | Lower half of split immediate |
| reg_off | input | 32 | Register offset value |
| base | input | 32 | Base register value |
| dst_idx | input | 4 | Destination register index |
| base_idx | input | 4 | Base register index |
| mem_rdata | input | 32 | Raw data returned by memory for a load |
| st_wdata | input | 32 | Register value to store |
| out_valid | output | 1 | Registered results are fresh |
| eff_addr | output | 32 | Access address |
| wb_value | output | 32 | New base register value |
| wb_en | output | 1 | Write `wb_value` back to the base register |
| acc_size | output | 2 | 0 byte, 1 halfword, 2 word |
| is_load | output | 1 | Access direction, 1 = load |
| load_result | output | 32 | Extended load value |
| store_data | output | 32 | Width-trimmed store value |
| wb_conflict | output | 1 | Load destination overlaps base with writeback |

## Verification
Every result is due exactly one rising edge after the request is sampled, since only the output register lies between inputs and outputs. The bench therefore changes inputs on a falling edge and reads the outputs on the following falling edge, half a period after they update. The hold behaviour is checked the same way. The bench drops `req_valid`, changes every input, and reads the outputs one falling edge later to confirm that nothing moved except `out_valid`.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

    // Offset source codes on off_kind
    localparam logic [1:0] OFF_IMM12 = 2'd0;
    localparam logic [1:0] OFF_SPLIT = 2'd1;
    localparam logic [1:0] OFF_REG   = 2'd2;
    localparam logic [1:0] OFF_NONE  = 2'd3;

    // Access size codes on acc_size
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // Control field, bit 4 down to bit 0
    typedef struct packed {
        logic pre;
        logic up;
        logic bsel;
        logic wback;
        logic load;
    } ctl_t;

endpackage

// File: rtl/lsag_offset.sv
module lsag_offset #(
    parameter int DW    = 32,
    parameter int IMM_W = 12,
    parameter int NIB_W = 4
) (
    input  logic [1:0]       kind,
    input  logic [IMM_W-1:0] imm,
    input  logic [NIB_W-1:0] hi,
    input  logic [NIB_W-1:0] lo,
    input  logic [DW-1:0]    roff,
    output logic [DW-1:0]    off
);
    import lsag_pkg::*;

    localparam int SPLIT_W = 2 * NIB_W;

    always_comb begin
        unique case (kind)
            OFF_IMM12: off = {{(DW-IMM_W){1'b0}}, imm};
            OFF_SPLIT: off = {{(DW-SPLIT_W){1'b0}}, hi, lo};
            OFF_REG:   off = roff;
            default:   off = '0;
        endcase
    end

endmodule

// File: rtl/lsag_addr.sv
module lsag_addr #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] off,
    input  logic          up,
    input  logic          pre,
    output logic [DW-1:0] eff,
    output logic [DW-1:0] upd
);
    logic [DW-1:0] moved;

    // One shared adder: subtraction via inverted operand plus carry-in
    always_comb begin
        moved = base + (up ? off : ~off) + {{(DW-1){1'b0}}, ~up};
        upd   = moved;
        eff   = pre ? moved : base;
    end

endmodule

// File: rtl/lsag_extend.sv
module lsag_extend #(
    parameter int DW = 32
) (
    input  logic          half_mode,
    input  logic [1:0]    ext_code,
    input  logic          bsel,
    input  logic          load,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] wdata,
    output logic [1:0]    size,
    output logic [DW-1:0] ld_res,
    output logic [DW-1:0] st_res
);
    import lsag_pkg::*;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    logic          is_signed;
    logic [DW-1:0] byte_v;
    logic [DW-1:0] half_v;
    logic [DW-1:0] ext_v;

    always_comb begin
        if (half_mode) begin
            size      = ext_code[0] ? SZ_HALF : SZ_BYTE;
            is_signed = ext_code[1];
        end else begin
            size      = bsel ? SZ_BYTE : SZ_WORD;
            is_signed = 1'b0;
        end

        byte_v = {{(DW-BYTE_W){is_signed & rdata[BYTE_W-1]}}, rdata[BYTE_W-1:0]};
        half_v = {{(DW-HALF_W){is_signed & rdata[HALF_W-1]}}, rdata[HALF_W-1:0]};

        unique case (size)
            SZ_BYTE: begin
                ext_v  = byte_v;
                st_res = {{(DW-BYTE_W){1'b0}}, wdata[BYTE_W-1:0]};
            end
            SZ_HALF: begin
                ext_v  = half_v;
                st_res = {{(DW-HALF_W){1'b0}}, wdata[HALF_W-1:0]};
            end
            default: begin
                ext_v  = rdata;
                st_res = wdata;
            end
        endcase

        ld_res = load ? ext_v : '0;
        if (load) begin
            st_res = '0;
        end
    end

endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
    parameter int DW    = 32,
    parameter int IMM_W = 12,
    parameter int NIB_W = 4,
    parameter int RID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [4:0]       ctl_field,
    input  logic [1:0]       off_kind,
    input  logic             half_mode,
    input  logic [1:0]       ext_code,
    input  logic [IMM_W-1:0] imm12,
    input  logic [NIB_W-1:0] imm_hi,
    input  logic [NIB_W-1:0] imm_lo,
    input  logic [DW-1:0]    reg_off,
    input  logic [DW-1:0]    base,
    input  logic [RID_W-1:0] dst_idx,
    input  logic [RID_W-1:0] base_idx,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [DW-1:0]    st_wdata,
    output logic             out_valid,
    output logic [DW-1:0]    eff_addr,
    output logic [DW-1:0]    wb_value,
    output logic             wb_en,
    output logic [1:0]       acc_size,
    output logic             is_load,
    output logic [DW-1:0]    load_result,
    output logic [DW-1:0]    store_data,
    output logic             wb_conflict
);
    import lsag_pkg::*;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] addr;
        logic [DW-1:0] wbv;
        logic          wben;
        logic [1:0]    size;
        logic          load;
        logic [DW-1:0] ldres;
        logic [DW-1:0] stdat;
        logic          clash;
    } state_t;

    ctl_t          ctl;
    logic [DW-1:0] off_w;
    logic [DW-1:0] eff_w;
    logic [DW-1:0] upd_w;
    logic [1:0]    size_w;
    logic [DW-1:0] ldres_w;
    logic [DW-1:0] stres_w;
    logic          wb_req;
    logic          clash_w;
    state_t        st_d;
    state_t        st_q;

    assign ctl = ctl_t'(ctl_field);

    lsag_offset #(.DW(DW), .IMM_W(IMM_W), .NIB_W(NIB_W)) off_i (
        .kind (off_kind),
        .imm  (imm12),
        .hi   (imm_hi),
        .lo   (imm_lo),
        .roff (reg_off),
        .off  (off_w)
    );

    lsag_addr #(.DW(DW)) addr_i (
        .base (base),
        .off  (off_w),
        .up   (ctl.up),
        .pre  (ctl.pre),
        .eff  (eff_w),
        .upd  (upd_w)
    );

    lsag_extend #(.DW(DW)) ext_i (
        .half_mode (half_mode),
        .ext_code  (ext_code),
        .bsel      (ctl.bsel),
        .load      (ctl.load),
        .rdata     (mem_rdata),
        .wdata     (st_wdata),
        .size      (size_w),
        .ld_res    (ldres_w),
        .st_res    (stres_w)
    );

    always_comb begin
        // Post-indexed always updates the base; pre-indexed only on request
        wb_req  = ~ctl.pre | ctl.wback;
        clash_w = ctl.load & wb_req & (dst_idx == base_idx);

        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.addr  = eff_w;
            st_d.wbv   = upd_w;
            st_d.wben  = wb_req & ~clash_w;
            st_d.size  = size_w;
            st_d.load  = ctl.load;
            st_d.ldres = ldres_w;
            st_d.stdat = stres_w;
            st_d.clash = clash_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign eff_addr    = st_q.addr;
    assign wb_value    = st_q.wbv;
    assign wb_en       = st_q.wben;
    assign acc_size    = st_q.size;
    assign is_load     = st_q.load;
    assign load_result = st_q.ldres;
    assign store_data  = st_q.stdat;
    assign wb_conflict = st_q.clash;

endmodule

// File: rtl/lsu_addr_gen_chk.sv
module lsu_addr_gen_chk #(
    parameter int DW    = 32,
    parameter int RID_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [4:0]       ctl_field,
    input logic [DW-1:0]    base,
    input logic [RID_W-1:0] dst_idx,
    input logic [RID_W-1:0] base_idx,
    input logic             out_valid,
    input logic [DW-1:0]    eff_addr,
    input logic [DW-1:0]    wb_value,
    input logic             wb_en,
    input logic [1:0]       acc_size,
    input logic             is_load,
    input logic [DW-1:0]    load_result,
    input logic             wb_conflict
);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R1
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(eff_addr) && $stable(wb_value) && $stable(load_result)));

    // R4
    post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ctl_field[4]) |=> (eff_addr == $past(base)));

    // R4
    post_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ctl_field[4] && !(ctl_field[0] && dst_idx == base_idx)) |=> wb_en);

    // R5
    pre_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctl_field[4] && !ctl_field[1]) |=> (!wb_en && eff_addr == wb_value));

    // R6
    dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (is_load == $past(ctl_field[0])));

    // R9
    store_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !is_load) |-> (load_result == '0));

    // R7
    size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (acc_size != 2'd3));

    // R10
    conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_conflict |-> (is_load && !wb_en));

    // R10
    conflict_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctl_field[0] && dst_idx == base_idx && (!ctl_field[4] || ctl_field[1]))
        |=> wb_conflict);

endmodule

bind lsu_addr_gen lsu_addr_gen_chk #(.DW(DW), .RID_W(RID_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .ctl_field   (ctl_field),
    .base        (base),
    .dst_idx     (dst_idx),
    .base_idx    (base_idx),
    .out_valid   (out_valid),
    .eff_addr    (eff_addr),
    .wb_value    (wb_value),
    .wb_en       (wb_en),
    .acc_size    (acc_size),
    .is_load     (is_load),
    .load_result (load_result),
    .wb_conflict (wb_conflict)
);

// File: tb/lsu_addr_gen_tb.sv
module lsu_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  ctl_field = '0;
    logic [1:0]  off_kind = '0;
    logic        half_mode = 1'b0;
    logic [1:0]  ext_code = '0;
    logic [11:0] imm12 = '0;
    logic [3:0]  imm_hi = '0;
    logic [3:0]  imm_lo = '0;
    logic [31:0] reg_off = '0;
    logic [31:0] base = '0;
    logic [3:0]  dst_idx = 4'd1;
    logic [3:0]  base_idx = 4'd2;
    logic [31:0] mem_rdata = '0;
    logic [31:0] st_wdata = '0;
    logic        out_valid;
    logic [31:0] eff_addr;
    logic [31:0] wb_value;
    logic        wb_en;
    logic [1:0]  acc_size;
    logic        is_load;
    logic [31:0] load_result;
    logic [31:0] store_data;
    logic        wb_conflict;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lsu_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ctl_field(ctl_field),
        .off_kind(off_kind), .half_mode(half_mode), .ext_code(ext_code),
        .imm12(imm12), .imm_hi(imm_hi), .imm_lo(imm_lo), .reg_off(reg_off),
        .base(base), .dst_idx(dst_idx), .base_idx(base_idx),
        .mem_rdata(mem_rdata), .st_wdata(st_wdata), .out_valid(out_valid),
        .eff_addr(eff_addr), .wb_value(wb_value), .wb_en(wb_en),
        .acc_size(acc_size), .is_load(is_load), .load_result(load_result),
        .store_data(store_data), .wb_conflict(wb_conflict)
    );

    typedef struct packed {
        logic [4:0]  ctl;
        logic [1:0]  kind;
        logic        hw;
        logic [1:0]  ext;
        logic [11:0] imm;
        logic [3:0]  hi;
        logic [3:0]  lo;
        logic [31:0] roff;
        logic [31:0] bval;
        logic [31:0] rdata;
        logic [31:0] wdata;
        logic [31:0] e_addr;
        logic [31:0] e_wb;
        logic        e_wben;
        logic [1:0]  e_size;
        logic [31:0] e_ld;
        logic [31:0] e_sd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // post, up, word load, imm12
        '{5'b01001, 2'd0, 1'b0, 2'd0, 12'h010, 4'h0, 4'h0, 32'h0, 32'h00001000,
          32'hDEADBEEF, 32'h99999999, 32'h00001000, 32'h00001010, 1'b1, 2'd2, 32'hDEADBEEF, 32'h0},
        // pre, down, no writeback, word store
        '{5'b10000, 2'd0, 1'b0, 2'd0, 12'h004, 4'h0, 4'h0, 32'h0, 32'h00002000,
          32'hFFFFFFFF, 32'h12345678, 32'h00001FFC, 32'h00001FFC, 1'b0, 2'd2, 32'h0, 32'h12345678},
        // pre, up, writeback, byte load, split immediate
        '{5'b11111, 2'd1, 1'b0, 2'd0, 12'h000, 4'hA, 4'h5, 32'h0, 32'h00003000,
          32'h123456F0, 32'h0, 32'h000030A5, 32'h000030A5, 1'b1, 2'd0, 32'h000000F0, 32'h0},
        // half mode signed byte load, register offset
        '{5'b11001, 2'd2, 1'b1, 2'd2, 12'h000, 4'h0, 4'h0, 32'h100, 32'h00004000,
          32'h00000080, 32'h0, 32'h00004100, 32'h00004100, 1'b0, 2'd0, 32'hFFFFFF80, 32'h0},
        // half mode signed halfword load, post down, byte-select set but ignored
        '{5'b00101, 2'd2, 1'b1, 2'd3, 12'h000, 4'h0, 4'h0, 32'h20, 32'h00005000,
          32'h00018000, 32'h0, 32'h00005000, 32'h00004FE0, 1'b1, 2'd1, 32'hFFFF8000, 32'h0},
        // half mode unsigned halfword load
        '{5'b11011, 2'd1, 1'b1, 2'd1, 12'h000, 4'h0, 4'hF, 32'h0, 32'h00006000,
          32'hFFFF8001, 32'h0, 32'h0000600F, 32'h0000600F, 1'b1, 2'd1, 32'h00008001, 32'h0},
        // half mode halfword store, pre down writeback to zero
        '{5'b10010, 2'd1, 1'b1, 2'd1, 12'h000, 4'h1, 4'h0, 32'h0, 32'h00000010,
          32'h0, 32'hAABBCCDD, 32'h00000000, 32'h00000000, 1'b1, 2'd1, 32'h0, 32'h0000CCDD},
        // word mode byte store, post up, wrap past the top
        '{5'b01100, 2'd0, 1'b0, 2'd0, 12'hFFF, 4'h0, 4'h0, 32'h0, 32'hFFFFF001,
          32'h0, 32'h11223344, 32'hFFFFF001, 32'h00000000, 1'b1, 2'd0, 32'h0, 32'h00000044},
        // pre down below zero
        '{5'b10001, 2'd0, 1'b0, 2'd0, 12'h001, 4'h0, 4'h0, 32'h0, 32'h00000000,
          32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 2'd2, 32'h0, 32'h0},
        // offset kind 3: zero offset
        '{5'b11011, 2'd3, 1'b0, 2'd0, 12'h077, 4'h0, 4'h0, 32'h55, 32'h00007000,
          32'h00000005, 32'h0, 32'h00007000, 32'h00007000, 1'b1, 2'd2, 32'h00000005, 32'h0},
        // half mode unsigned byte load
        '{5'b11001, 2'd0, 1'b1, 2'd0, 12'h002, 4'h0, 4'h0, 32'h0, 32'h00008000,
          32'hFFFFFF81, 32'h0, 32'h00008002, 32'h00008002, 1'b0, 2'd0, 32'h00000081, 32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        ctl_field = v.ctl;   off_kind = v.kind;  half_mode = v.hw;
        ext_code  = v.ext;   imm12    = v.imm;   imm_hi    = v.hi;
        imm_lo    = v.lo;    reg_off  = v.roff;  base      = v.bval;
        mem_rdata = v.rdata; st_wdata = v.wdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        vec_t v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset out_valid", {31'b0, out_valid}, 32'h0);
        chk("R1 reset eff_addr", eff_addr, 32'h0);
        chk("R1 reset wb_en", {31'b0, wb_en}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            req_valid = 1'b1;
            @(negedge clk);
            chk("R1 out_valid", {31'b0, out_valid}, 32'h1);
            chk("R2 R3 R4 R5 eff_addr", eff_addr, VECS[i].e_addr);
            chk("R3 R4 R5 wb_value", wb_value, VECS[i].e_wb);
            chk("R4 R5 wb_en", {31'b0, wb_en}, {31'b0, VECS[i].e_wben});
            chk("R7 R8 acc_size", {30'b0, acc_size}, {30'b0, VECS[i].e_size});
            chk("R6 is_load", {31'b0, is_load}, {31'b0, VECS[i].ctl[0]});
            chk("R7 R8 load_result", load_result, VECS[i].e_ld);
            chk("R9 store_data", store_data, VECS[i].e_sd);
            chk("R10 no conflict", {31'b0, wb_conflict}, 32'h0);
        end

        // R1 hold: drop valid, change every input, outputs keep last values
        v = VECS[0];
        drive(v);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1 hold out_valid", {31'b0, out_valid}, 32'h0);
        chk("R1 hold eff_addr", eff_addr, VECS[NV-1].e_addr);
        chk("R1 hold load_result", load_result, VECS[NV-1].e_ld);

        // R10 pre-indexed load with writeback onto its own base
        v = VECS[2];
        drive(v);
        dst_idx = 4'd7; base_idx = 4'd7;
        req_valid = 1'b1;
        @(negedge clk);
        chk("R10 conflict flag", {31'b0, wb_conflict}, 32'h1);
        chk("R10 conflict wb_en", {31'b0, wb_en}, 32'h0);
        chk("R10 conflict load_result", load_result, 32'h000000F0);

        // R10 post-indexed load onto its own base
        v = VECS[0];
        drive(v);
        @(negedge clk);
        chk("R10 post conflict flag", {31'b0, wb_conflict}, 32'h1);
        chk("R10 post conflict wb_en", {31'b0, wb_en}, 32'h0);

        // R10 store with equal indices is not a conflict
        v = VECS[6];
        drive(v);
        @(negedge clk);
        chk("R10 store no conflict", {31'b0, wb_conflict}, 32'h0);
        chk("R10 store wb_en", {31'b0, wb_en}, 32'h1);

        // R10 pre-indexed load without writeback, equal indices
        v = VECS[3];
        drive(v);
        @(negedge clk);
        chk("R10 no-wb load no conflict", {31'b0, wb_conflict}, 32'h0);

        req_valid = 1'b0;
        dst_idx = 4'd1; base_idx = 4'd2;
        @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule